// File: doc/BRIEF.md
# Bit-Masked Control Register Bank

This block holds the control words for a camera receive PHY and lets software change any single field with one bus write, without reading the word first. Each 32-bit write word has two halves. The lower 16 bits carry the new data. The upper 16 bits carry a per-bit write enable for that data: a lower bit changes only when its partner bit, sixteen places higher, is set. Two drivers can therefore own different fields of the same word without racing each other.

The bank has three writable control words and one read-only status word. The lane word drives the per-lane enable, forced-receive, forced-stop and turnaround-disable fields. The turnaround word drives the turnaround-request field and the two receiver clock-invert selects. The test word drives the PHY's test-port pins: data-in, enable, clock and clear. The status word returns the PHY's 8-bit test data-out.

The bus is a plain valid/write/address interface. A write takes effect at the clock edge on which it is presented. Read data is registered and appears one cycle after the read is accepted.

Top module: `maskreg_bank`

## Requirements
- R1: After reset, every writable bit is zero, every control output is zero, and `bus_rdata` is zero.
- R2: On a write, data bit i (0 to 15) takes `bus_wdata[i]` only when `bus_wdata[i+16]` is 1. Every other bit keeps its previous value.
- R3: A write whose upper half `bus_wdata[31:16]` is all zero changes nothing, whatever its lower half holds.
- R4: Word address 0 is the turnaround word. Bits 3:0 drive `turn_req`, bit 10 drives `clkinv_rx0` and bit 11 drives `clkinv_rx1`. Its other bits cannot be set and read as zero, so a write of 0xFFFFFFFF reads back as 0x00000C0F.
- R5: Word address 1 is the lane word. Bits 3:0 drive `lane_en`, bits 7:4 drive `lane_force_rx`, bits 11:8 drive `lane_force_stop` and bits 15:12 drive `lane_turn_dis`.
- R6: Word address 2 is the test word. Bits 7:0 drive `tst_din`, bit 8 drives `tst_en`, bit 9 drives `tst_clk` and bit 10 drives `tst_clr`. Bits 15:11 read as zero.
- R7: A read of word address 3 returns `tst_dout` in bits 7:0 and zero in bits 31:8. A write to address 3 changes no register.
- R8: Bits 31:16 of `bus_rdata` are always zero.
- R9: `bus_rdata` is loaded at the clock edge that accepts a read (`bus_valid`=1, `bus_write`=0). It holds its value on every other cycle.
- R10: Addresses above 3 read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Bus access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (4) | Word address |
| bus_wdata | input | 32 | Write data; upper half is the bit-enable |
| bus_rdata | output | 32 | Registered read data |
| turn_req | output | 4 | Per-lane turnaround request |
| clkinv_rx0 | output | 1 | Clock-invert select, receiver 0 |
| clkinv_rx1 | output | 1 | Clock-invert select, receiver 1 |
| lane_en | output | 4 | Per-lane enable |
| lane_force_rx | output | 4 | Per-lane forced receive mode |
| lane_force_stop | output | 4 | Per-lane forced stop state |
| lane_turn_dis | output | 4 | Per-lane turnaround disable |
| tst_din | output | 8 | Test-port data in |
| tst_en | output | 1 | Test-port enable |
| tst_clk | output | 1 | Test-port clock |
| tst_clr | output | 1 | Test-port clear |
| tst_dout | input | 8 | Test-port data out, reported at address 3 |

## Verification
The masked write is exercised with five kinds of enable pattern:
- **Single-bit enables** show that only the selected bit moves.
- **Full-field enables with alternating data** show that each field lands at its own pins, and that neighbouring fields are untouched.
- **All-ones enables** expose which bits of each word are implemented.
- **An all-zero enable carrying non-zero data** separates a true masked write from a plain write.
- **Clearing one bit while its neighbour stays set** separates per-bit update from whole-word replacement.

Writes aimed at the status address and at unmapped addresses are each followed by readback of every control word. This shows that the decode does not alias onto a real register.

// File: rtl/maskreg_pkg.sv
package maskreg_pkg;
    localparam int DATA_W   = 32;
    localparam int HALF_W   = DATA_W / 2;
    localparam int LANES    = 4;
    localparam int TST_W    = 8;
    localparam int NUM_CTRL = 3;

    localparam int IDX_TURN = 0;
    localparam int IDX_LANE = 1;
    localparam int IDX_TEST = 2;
    localparam int IDX_STAT = 3;

    // Bits that physically exist in each control word.
    function automatic logic [HALF_W-1:0] impl_mask(input int idx);
        logic [HALF_W-1:0] m;
        m = '0;
        case (idx)
            IDX_TURN: m = 16'h0C0F;
            IDX_LANE: m = 16'hFFFF;
            IDX_TEST: m = 16'h07FF;
            default:  m = '0;
        endcase
        return m;
    endfunction
endpackage

// File: rtl/maskreg_cell.sv
module maskreg_cell
    import maskreg_pkg::*;
#(
    parameter logic [HALF_W-1:0] IMPL = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [HALF_W-1:0] q
);
    logic [HALF_W-1:0] bit_en;

    assign bit_en = wdata[DATA_W-1:HALF_W] & IMPL;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else if (wr_en) q <= (q & ~bit_en) | (wdata[HALF_W-1:0] & bit_en);
    end

    // Bits whose enable is clear must not move across a write.
    assert_masked_bits_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((q ^ $past(q)) & ~$past(wdata[DATA_W-1:HALF_W])) == '0);

    // Bits whose enable is set take the written data.
    assert_enabled_bits_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((q ^ $past(wdata[HALF_W-1:0])) & $past(wdata[DATA_W-1:HALF_W]) & IMPL) == '0);

    assert_zero_mask_no_effect_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wdata[DATA_W-1:HALF_W] == '0) |=> $stable(q));

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(q));
endmodule

// File: rtl/maskreg_rdmux.sv
module maskreg_rdmux
    import maskreg_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0]                addr,
    input  logic [NUM_CTRL-1:0][HALF_W-1:0]  ctrl_q,
    input  logic [TST_W-1:0]                 stat,
    output logic [DATA_W-1:0]                rword
);
    always_comb begin
        rword = '0;
        for (int i = 0; i < NUM_CTRL; i++) begin
            if (addr == ADDR_W'(i)) rword[HALF_W-1:0] = ctrl_q[i];
        end
        if (addr == ADDR_W'(IDX_STAT)) rword[TST_W-1:0] = stat;
    end
endmodule

// File: rtl/maskreg_bank.sv
module maskreg_bank
    import maskreg_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [3:0]        turn_req,
    output logic              clkinv_rx0,
    output logic              clkinv_rx1,
    output logic [3:0]        lane_en,
    output logic [3:0]        lane_force_rx,
    output logic [3:0]        lane_force_stop,
    output logic [3:0]        lane_turn_dis,
    output logic [7:0]        tst_din,
    output logic              tst_en,
    output logic              tst_clk,
    output logic              tst_clr,
    input  logic [7:0]        tst_dout
);
    logic                            wr_fire;
    logic                            rd_fire;
    logic [NUM_CTRL-1:0][HALF_W-1:0] ctrl_q;
    logic [DATA_W-1:0]               rd_word;

    assign wr_fire = bus_valid && bus_write;
    assign rd_fire = bus_valid && !bus_write;

    for (genvar g = 0; g < NUM_CTRL; g++) begin : g_word
        logic sel_wr;
        assign sel_wr = wr_fire && (bus_addr == ADDR_W'(g));
        maskreg_cell #(.IMPL(impl_mask(g))) u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (sel_wr),
            .wdata (bus_wdata),
            .q     (ctrl_q[g])
        );
    end

    maskreg_rdmux #(.ADDR_W(ADDR_W)) u_rdmux (
        .addr   (bus_addr),
        .ctrl_q (ctrl_q),
        .stat   (tst_dout),
        .rword  (rd_word)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bus_rdata <= '0;
        else if (rd_fire) bus_rdata <= rd_word;
    end

    // Field placement
    assign turn_req   = ctrl_q[IDX_TURN][LANES-1:0];
    assign clkinv_rx0 = ctrl_q[IDX_TURN][10];
    assign clkinv_rx1 = ctrl_q[IDX_TURN][11];

    assign lane_en         = ctrl_q[IDX_LANE][3:0];
    assign lane_force_rx   = ctrl_q[IDX_LANE][7:4];
    assign lane_force_stop = ctrl_q[IDX_LANE][11:8];
    assign lane_turn_dis   = ctrl_q[IDX_LANE][15:12];

    assign tst_din = ctrl_q[IDX_TEST][TST_W-1:0];
    assign tst_en  = ctrl_q[IDX_TEST][8];
    assign tst_clk = ctrl_q[IDX_TEST][9];
    assign tst_clr = ctrl_q[IDX_TEST][10];

    assert_upper_half_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[31:16] == 16'h0);

    assert_status_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_fire && bus_addr == ADDR_W'(IDX_STAT)) |=> bus_rdata == {24'h0, $past(tst_dout)});

    assert_status_write_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire && bus_addr == ADDR_W'(IDX_STAT)) |=> $stable(ctrl_q));

    assert_unmapped_write_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire && bus_addr > ADDR_W'(IDX_STAT)) |=> $stable(ctrl_q));

    assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_fire |=> $stable(bus_rdata));
endmodule

// File: tb/maskreg_bank_test.sv
module maskreg_bank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  turn_req, lane_en, lane_force_rx, lane_force_stop, lane_turn_dis;
    logic        clkinv_rx0, clkinv_rx1, tst_en, tst_clk, tst_clr;
    logic [7:0]  tst_din;
    logic [7:0]  tst_dout = 8'h00;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    maskreg_bank uut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .turn_req(turn_req), .clkinv_rx0(clkinv_rx0), .clkinv_rx1(clkinv_rx1),
        .lane_en(lane_en), .lane_force_rx(lane_force_rx),
        .lane_force_stop(lane_force_stop), .lane_turn_dis(lane_turn_dis),
        .tst_din(tst_din), .tst_en(tst_en), .tst_clk(tst_clk), .tst_clr(tst_clr),
        .tst_dout(tst_dout)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a; bus_wdata = 32'hDEAD_BEEF;
        @(negedge clk);
        bus_valid = 1'b0;
        d = bus_rdata;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        check("R1 outputs", {turn_req, clkinv_rx0, clkinv_rx1, lane_en, lane_force_rx,
              lane_force_stop, lane_turn_dis, tst_din, tst_en, tst_clk, tst_clr}, 32'h0);
        check("R1 rdata", bus_rdata, 32'h0);
        for (int a = 0; a < 3; a++) begin
            rd(4'(a), v);
            check("R1 word", v, 32'h0);
        end
    endtask

    task automatic t_single_bit;
        logic [31:0] v;
        wr(4'd1, 32'h0001_FFFF);
        check("R2 single bit", {16'h0, lane_turn_dis, lane_force_stop, lane_force_rx, lane_en}, 32'h0001);
        wr(4'd1, 32'h0020_FFFF);
        rd(4'd1, v);
        check("R2 second bit keeps first", v, 32'h0000_0021);
        wr(4'd1, 32'h0001_0000);
        rd(4'd1, v);
        check("R2 clear one bit", v, 32'h0000_0020);
    endtask

    task automatic t_zero_mask;
        logic [31:0] v;
        wr(4'd1, 32'h0000_FFFF);
        rd(4'd1, v);
        check("R3 zero mask lane", v, 32'h0000_0020);
        wr(4'd0, 32'h0000_FFFF);
        check("R3 zero mask turn pins", {26'h0, turn_req, clkinv_rx0, clkinv_rx1}, 32'h0);
    endtask

    task automatic t_lane_fields;
        wr(4'd1, 32'hFFFF_0000);
        wr(4'd1, 32'h000F_0005);
        wr(4'd1, 32'h00F0_00A0);
        wr(4'd1, 32'h0F00_0C00);
        wr(4'd1, 32'hF000_3000);
        check("R5 lane_en", 32'(lane_en), 32'h5);
        check("R5 lane_force_rx", 32'(lane_force_rx), 32'hA);
        check("R5 lane_force_stop", 32'(lane_force_stop), 32'hC);
        check("R5 lane_turn_dis", 32'(lane_turn_dis), 32'h3);
    endtask

    task automatic t_turn_word;
        logic [31:0] v;
        wr(4'd0, 32'hFFFF_FFFF);
        rd(4'd0, v);
        check("R4 implemented bits", v, 32'h0000_0C0F);
        wr(4'd0, 32'h0400_0000);
        check("R4 pins", {26'h0, turn_req, clkinv_rx0, clkinv_rx1}, {26'h0, 4'hF, 1'b0, 1'b1});
        rd(4'd0, v);
        check("R4 readback", v, 32'h0000_080F);
    endtask

    task automatic t_test_word;
        logic [31:0] v;
        wr(4'd2, 32'h00FF_00A5);
        wr(4'd2, 32'h0100_0100);
        check("R6 pins", {20'h0, tst_clr, tst_clk, tst_en, tst_din}, 32'h0000_01A5);
        rd(4'd2, v);
        check("R6 readback", v, 32'h0000_01A5);
        wr(4'd2, 32'hFFFF_FFFF);
        rd(4'd2, v);
        check("R6 all ones", v, 32'h0000_07FF);
        check("R8 upper half", 32'(v[31:16]), 32'h0);
    endtask

    task automatic t_status;
        logic [31:0] v, l0, l1, l2;
        tst_dout = 8'h3C;
        rd(4'd3, v);
        check("R7 status", v, 32'h0000_003C);
        rd(4'd0, l0); rd(4'd1, l1); rd(4'd2, l2);
        wr(4'd3, 32'hFFFF_0000);
        rd(4'd0, v); check("R7 write ignored w0", v, l0);
        rd(4'd1, v); check("R7 write ignored w1", v, l1);
        rd(4'd2, v); check("R7 write ignored w2", v, l2);
        tst_dout = 8'hC3;
        rd(4'd3, v);
        check("R7 status follows", v, 32'h0000_00C3);
    endtask

    task automatic t_unmapped;
        logic [31:0] v, l0, l1, l2;
        rd(4'd0, l0); rd(4'd1, l1); rd(4'd2, l2);
        wr(4'd4, 32'hFFFF_0000);
        wr(4'd9, 32'hFFFF_5555);
        rd(4'd0, v); check("R10 no alias w0", v, l0);
        rd(4'd1, v); check("R10 no alias w1", v, l1);
        rd(4'd2, v); check("R10 no alias w2", v, l2);
        rd(4'd7, v); check("R10 unmapped read", v, 32'h0);
    endtask

    task automatic t_hold;
        logic [31:0] v;
        rd(4'd1, v);
        wr(4'd1, 32'hFFFF_0000);
        repeat (3) @(negedge clk);
        check("R9 hold after write", bus_rdata, v);
        rd(4'd1, v);
        check("R9 new read", v, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_single_bit();
        t_zero_mask();
        t_lane_fields();
        t_turn_word();
        t_test_word();
        t_status();
        t_unmapped();
        t_hold();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog actual=running expected=done");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule